// File: doc/BRIEF.md
# Steerable Interval Watchdog

This block is a watchdog timer configured through one byte-wide register. The register holds a multiplier field and a resolution code. Together they give a timeout measured in periods of an external 16 Hz enable strobe: the multiplier is scaled by four raised to the resolution code. Software keeps the watchdog from expiring by writing the register or by reading it. Either access reloads the count from the programmed interval.

When the count runs out, the block raises a sticky expiry flag and then takes one of two actions, chosen by the top bit of the register. With the bit clear, it emits a single-cycle interrupt pulse and stops counting until the next access. With the bit set, it emits a single-cycle reset request and clears the whole register, which leaves the watchdog disarmed. A multiplier of zero, and therefore a register value of zero, keeps the timer idle.

The field widths and the way the interval is formed are parameters. The expiry action, the counter and the register each live in their own submodule.

Top module: `wdg_steer`

## Requirements
- R1: While and after reset, `wdg_flag`, `wdg_irq` and `wdg_rst_req` are 0 and `cfg_rdata` reads 0x00.
- R2: A write stores `cfg_wdata` into the configuration byte, which appears on `cfg_rdata` from the next cycle. Bits [1:0] are the resolution code, bits [6:2] the multiplier and bit 7 the steering bit.
- R3: After a restart, expiry happens on tick number (1 << 2·res) × mult counted from the restart, and not before it.
- R4: Every write and every read of the register clears `wdg_flag` on the following cycle.
- R5: On expiry `wdg_flag` becomes 1 and stays 1 until the next register access. With steering bit 7 clear, `wdg_irq` is 1 for exactly one cycle.
- R6: After an interrupt expiry the count stops, and further ticks produce no pulse until a register access restarts it.
- R7: With steering bit 7 set at expiry, `wdg_rst_req` is 1 for exactly one cycle, `wdg_irq` stays 0 and the register reads 0x00 afterwards.
- R8: A read restarts the count from the stored value, so the full interval is counted again from the read.
- R9: A multiplier of zero, whether written as 0x00 or with only resolution or steering bits set, disables the timer: no expiry occurs for any number of ticks.
- R10: A tick that arrives in the same cycle as a register access is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration byte |
| cfg_rd | input | 1 | Read strobe; restarts the count |
| cfg_wdata | input | 8 | Configuration byte to write |
| cfg_rdata | output | 8 | Current configuration byte |
| tick_16hz | input | 1 | One-cycle enable at 16 Hz, one count unit |
| wdg_flag | output | 1 | Sticky expiry flag |
| wdg_irq | output | 1 | One-cycle interrupt pulse on expiry |
| wdg_rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The bench uses the default parameters: an 8-bit register, a 5-bit multiplier, a 2-bit resolution code and the shifter variant. With these, the counter is 11 bits wide. All four resolution codes can be exercised, including the longest interval of 1984 ticks (0x7F), which stays within the run length. The cases covered are expiry on the exact tick, restarts by read and by write, a tick that collides with an access, and the disabling encodings.

// File: rtl/wdg_steer_pkg.sv
package wdg_steer_pkg;

   typedef enum logic [1:0] {
      ACT_NONE  = 2'd0,
      ACT_IRQ   = 2'd1,
      ACT_RESET = 2'd2
   } expiry_act_e;

   // Bits needed for the largest interval: multiplier shifted by 2*(2^RES_W - 1)
   function automatic int unsigned cnt_width(input int unsigned mult_w,
                                             input int unsigned res_w);
      return mult_w + 2 * ((1 << res_w) - 1);
   endfunction

endpackage

// File: rtl/wdg_cfg_reg.sv
module wdg_cfg_reg #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              disarm,
   output logic [DATA_W-1:0] cfg_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (wr_en) begin
         cfg_q <= wr_data;
      end else if (disarm) begin
         cfg_q <= '0;
      end
   end

   AST_WRITE_STORES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (cfg_q == $past(wr_data))) else $error("cfg store");   // R2

endmodule

// File: rtl/wdg_interval.sv
module wdg_interval #(
   parameter int unsigned MULT_W      = 5,
   parameter int unsigned RES_W       = 2,
   parameter int unsigned CNT_W       = 11,
   parameter bit          USE_SHIFTER = 1'b1
) (
   input  logic [MULT_W-1:0] mult,
   input  logic [RES_W-1:0]  res,
   output logic [CNT_W-1:0]  interval
);

   localparam int unsigned PAD_W = CNT_W - MULT_W;

   logic [CNT_W-1:0] mult_ext;
   assign mult_ext = {{PAD_W{1'b0}}, mult};

   generate
      if (CNT_W < MULT_W) begin : g_bad_width
         $error("wdg_interval: CNT_W narrower than MULT_W");
      end
      if (USE_SHIFTER) begin : g_shift
         assign interval = mult_ext << {res, 1'b0};
      end else begin : g_mul
         logic [CNT_W-1:0] scale;
         assign scale    = CNT_W'(1) << {res, 1'b0};
         assign interval = mult_ext * scale;
      end
   endgenerate

endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown #(
   parameter int unsigned CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic             expire,
   output logic             running
);

   logic [CNT_W-1:0] cnt_q;

   assign expire = running && tick && !restart && (cnt_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         running <= 1'b0;
      end else if (restart) begin
         cnt_q   <= load_val;
         running <= (load_val != '0);
      end else if (expire) begin
         running <= 1'b0;
      end else if (running && tick) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (cnt_q != '0)) else $error("zero count while running");   // R3
   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !tick && !restart) |=> $stable(cnt_q)) else $error("count moved");   // R10
   AST_ZERO_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && load_val == '0) |=> !running) else $error("zero armed");   // R9
   AST_STOP_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !running) else $error("still running");   // R6

endmodule

// File: rtl/wdg_steer.sv
module wdg_steer #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned MULT_W      = 5,
   parameter int unsigned RES_W       = 2,
   parameter bit          USE_SHIFTER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              cfg_rd,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic              tick_16hz,
   output logic              wdg_flag,
   output logic              wdg_irq,
   output logic              wdg_rst_req
);

   import wdg_steer_pkg::*;

   localparam int unsigned CNT_W   = cnt_width(MULT_W, RES_W);
   localparam int unsigned FIELD_W = MULT_W + RES_W;
   localparam int unsigned STEER_B = DATA_W - 1;

   generate
      if (DATA_W < FIELD_W + 1) begin : g_bad_data
         $error("wdg_steer: DATA_W too small for fields plus steering bit");
      end
      if (MULT_W < 1 || RES_W < 1) begin : g_bad_field
         $error("wdg_steer: field widths must be at least 1");
      end
   endgenerate

   logic [DATA_W-1:0]  cfg_q;
   logic [FIELD_W-1:0] sel_field;
   logic [CNT_W-1:0]   interval;
   logic               restart;
   logic               expire;
   logic               running;
   logic               steer;
   expiry_act_e        act;

   assign restart   = cfg_wr | cfg_rd;
   assign sel_field = cfg_wr ? cfg_wdata[FIELD_W-1:0] : cfg_q[FIELD_W-1:0];
   assign steer     = cfg_q[STEER_B];
   assign cfg_rdata = cfg_q;

   always_comb begin
      act = ACT_NONE;
      if (expire) act = steer ? ACT_RESET : ACT_IRQ;
   end

   wdg_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr),
      .wr_data (cfg_wdata),
      .disarm  (act == ACT_RESET),
      .cfg_q   (cfg_q)
   );

   wdg_interval #(
      .MULT_W      (MULT_W),
      .RES_W       (RES_W),
      .CNT_W       (CNT_W),
      .USE_SHIFTER (USE_SHIFTER)
   ) u_interval (
      .mult     (sel_field[FIELD_W-1:RES_W]),
      .res      (sel_field[RES_W-1:0]),
      .interval (interval)
   );

   wdg_countdown #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (restart),
      .load_val (interval),
      .tick     (tick_16hz),
      .expire   (expire),
      .running  (running)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wdg_flag    <= 1'b0;
         wdg_irq     <= 1'b0;
         wdg_rst_req <= 1'b0;
      end else begin
         wdg_irq     <= (act == ACT_IRQ);
         wdg_rst_req <= (act == ACT_RESET);
         if (restart) begin
            wdg_flag <= 1'b0;
         end else if (act != ACT_NONE) begin
            wdg_flag <= 1'b1;
         end
      end
   end

   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wdg_irq |=> !wdg_irq) else $error("irq too long");   // R5
   AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wdg_rst_req |=> !wdg_rst_req) else $error("reset request too long");   // R7
   AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({wdg_irq, wdg_rst_req}) <= 1) else $error("both actions");   // R7
   AST_FLAG_WITH_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      (wdg_irq || wdg_rst_req) |-> wdg_flag) else $error("action without flag");   // R5
   AST_ACCESS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !wdg_flag) else $error("flag not cleared");   // R4
   AST_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
      wdg_rst_req |-> (cfg_rdata == '0)) else $error("config not cleared");   // R7
   AST_NO_IDLE_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !restart) |=> !(wdg_irq || wdg_rst_req)) else $error("idle expiry");   // R6

endmodule

// File: tb/wdg_steer_bench.sv
module wdg_steer_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0;
   logic       cfg_rd = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic       tick_16hz = 1'b0;
   logic       wdg_flag, wdg_irq, wdg_rst_req;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   wdg_steer u_wdg_steer (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_wr      (cfg_wr),
      .cfg_rd      (cfg_rd),
      .cfg_wdata   (cfg_wdata),
      .cfg_rdata   (cfg_rdata),
      .tick_16hz   (tick_16hz),
      .wdg_flag    (wdg_flag),
      .wdg_irq     (wdg_irq),
      .wdg_rst_req (wdg_rst_req)
   );

   task automatic chk(input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic do_write(input logic [7:0] v, input logic with_tick = 1'b0);
      cfg_wr = 1'b1; cfg_wdata = v; tick_16hz = with_tick;
      @(negedge clk);
      cfg_wr = 1'b0; tick_16hz = 1'b0;
   endtask

   task automatic do_read();
      cfg_rd = 1'b1;
      @(negedge clk);
      cfg_rd = 1'b0;
   endtask

   // n single-cycle ticks; counts action pulses seen after each one
   task automatic run_ticks(input int n, output int irqs, output int rsts);
      irqs = 0; rsts = 0;
      for (int i = 0; i < n; i++) begin
         tick_16hz = 1'b1;
         @(negedge clk);
         tick_16hz = 1'b0;
         if (wdg_irq) irqs++;
         if (wdg_rst_req) rsts++;
      end
   endtask

   task automatic t_reset();
      chk(wdg_flag, 0, "R1 flag in reset");
      chk(wdg_rst_req, 0, "R1 rst_req in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk(wdg_irq, 0, "R1 irq after reset");
      chk(wdg_rst_req, 0, "R1 rst_req after reset");
      chk(cfg_rdata, 0, "R1 rdata after reset");
   endtask

   task automatic t_interval(input logic [7:0] v, input int n, input string tag);
      int irqs, rsts;
      do_write(v);
      chk(cfg_rdata, v, {"R2 readback ", tag});
      run_ticks(n - 1, irqs, rsts);
      chk(irqs, 0, {"R3 no early expiry ", tag});
      chk(wdg_flag, 0, {"R3 flag early ", tag});
      run_ticks(1, irqs, rsts);
      chk(wdg_irq, 1, {"R3 R5 irq on last tick ", tag});
      chk(wdg_flag, 1, {"R5 flag set ", tag});
      chk(wdg_rst_req, 0, {"R5 no rst_req ", tag});
      @(negedge clk);
      chk(wdg_irq, 0, {"R5 irq one cycle ", tag});
      chk(wdg_flag, 1, {"R5 flag sticky ", tag});
   endtask

   task automatic t_stop();
      int irqs, rsts;
      t_interval(8'h05, 4, "stop");
      run_ticks(20, irqs, rsts);
      chk(irqs + rsts, 0, "R6 no pulse after stop");
      chk(wdg_flag, 1, "R6 flag kept");
   endtask

   task automatic t_clear();
      do_write(8'h04);
      chk(wdg_flag, 0, "R4 write clears flag");
      t_interval(8'h04, 1, "clr");
      do_read();
      chk(wdg_flag, 0, "R4 read clears flag");
   endtask

   task automatic t_steer();
      int irqs, rsts;
      do_write(8'h88);
      run_ticks(1, irqs, rsts);
      chk(wdg_rst_req, 0, "R7 no early rst_req");
      run_ticks(1, irqs, rsts);
      chk(wdg_rst_req, 1, "R7 rst_req on expiry");
      chk(wdg_irq, 0, "R7 no irq");
      chk(wdg_flag, 1, "R7 flag set");
      chk(cfg_rdata, 0, "R7 config cleared");
      @(negedge clk);
      chk(wdg_rst_req, 0, "R7 rst_req one cycle");
      run_ticks(10, irqs, rsts);
      chk(irqs + rsts, 0, "R7 disarmed after reset path");
   endtask

   task automatic t_read_restart();
      int irqs, rsts;
      do_write(8'h0C);
      run_ticks(2, irqs, rsts);
      do_read();
      chk(cfg_rdata, 8'h0C, "R8 read keeps value");
      run_ticks(2, irqs, rsts);
      chk(irqs, 0, "R8 read restarted count");
      run_ticks(1, irqs, rsts);
      chk(wdg_irq, 1, "R8 expiry after full interval");
      @(negedge clk);
      do_read();
      run_ticks(3, irqs, rsts);
      chk(irqs, 1, "R8 read re-arms after stop");
   endtask

   task automatic t_disable();
      int irqs, rsts;
      do_write(8'h00);
      run_ticks(100, irqs, rsts);
      chk(irqs + rsts, 0, "R9 zero value idle");
      do_write(8'h83);
      run_ticks(100, irqs, rsts);
      chk(irqs + rsts, 0, "R9 zero multiplier idle");
      chk(wdg_flag, 0, "R9 flag stays clear");
   endtask

   task automatic t_collide();
      int irqs, rsts;
      do_write(8'h0C, 1'b1);
      run_ticks(2, irqs, rsts);
      chk(irqs, 0, "R10 colliding tick ignored");
      run_ticks(1, irqs, rsts);
      chk(wdg_irq, 1, "R10 expiry on third tick");
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_interval(8'h0C, 3, "res0");
      t_interval(8'h05, 4, "res1");
      t_interval(8'h0A, 32, "res2");
      t_interval(8'h07, 64, "res3");
      t_interval(8'h7F, 1984, "max");
      t_stop();
      t_clear();
      t_steer();
      t_read_restart();
      t_disable();
      t_collide();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog timeout actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule